// File: doc/BRIEF.md
# Destination Address Filter with Loadable CAM

This block decides, one 48-bit destination address at a time, whether an incoming frame is for this station, and it labels accepted frames as multicast or broadcast. The address goes through a fixed chain of checks in priority order. Three mode inputs can open the filter: one for any unicast address, one for any group address, and one for the all-ones address. If none of these apply, the address is compared with a 16-entry content-addressable table of station addresses. Each table entry has its own enable bit.

The table is filled by a small load sequencer. When started, it walks a list of descriptors in system memory through a one-outstanding read port with one cycle of latency. Each descriptor supplies one 48-bit address. After the last descriptor, one more word provides the enable mask. The read stride follows a 16-bit or 32-bit data mode. While the block is held in its reset mode, a host can inspect any table entry through three 16-bit port views.

Top module: `addr_filter_cam`

## Requirements
- R1: With `promisc` set, an address whose byte 0 (bits [7:0] of `lookupAddr`) has bit 0 clear is accepted with neither class flag.
- R2: With `allMulti` set, an address with bit 0 of byte 0 set is accepted with `isMulticast` high. This check ranks above R3, so the all-ones address yields multicast when both modes are on.
- R3: With `acceptBcast` set and R1 and R2 not applying, the all-ones address is accepted with `isBroadcast` high.
- R4: Otherwise, an address equal to a table entry whose enable bit is set is accepted with no class flag. A matching entry whose enable bit is clear does not accept.
- R5: An address that passes none of the checks gives `resultValid` high with `accept`, `isMulticast` and `isBroadcast` low.
- R6: The result appears on the cycle after an `addrValid` cycle and lasts one cycle. An `addrValid` seen while `loadBusy` is high produces no result.
- R7: A load with count n (the low 5 bits of `countInit`) issues reads for words 1, 2 and 3 of each descriptor. Word k of descriptor e is at {`segBase`, `ptrInit` + e·4W} + k·W, where W is 2 bytes, or 4 bytes when `wide32` is set. With a zero count, only the enable-mask word is read. `memRdEn` is high only while loading.
- R8: Descriptor word 1 holds address bytes 0-1, word 2 bytes 2-3 and word 3 bytes 4-5, with the low byte first. Only bits [15:0] of `memRdData` are used, in both modes.
- R9: Word 0 of descriptor n becomes the enable mask (bit i enables entry i). `loadDone` pulses for one cycle right after the read data for that word is taken. `loadBusy` lasts 6n+2 cycles. A `loadStart` during a load is ignored.
- R10: While `resetMode` is high, `portData` shows entry `entrySel` as follows: `portSel` 0 gives bytes 5:4, 1 gives bytes 3:2, 2 gives bytes 1:0, and 3 gives zero. While `resetMode` is low, `portData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wide32 | input | 1 | Load uses 32-bit slots instead of 16-bit words |
| loadStart | input | 1 | Start a table load (one cycle) |
| segBase | input | 16 | Upper half of the descriptor address |
| ptrInit | input | 16 | Starting lower half of the descriptor address |
| countInit | input | 16 | Descriptor count; only the low 5 bits are used |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 32 | Byte address of the read |
| memRdData | input | 32 | Read data, valid the cycle after the request |
| addrValid | input | 1 | Lookup address strobe |
| lookupAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| promisc | input | 1 | Accept any unicast address |
| allMulti | input | 1 | Accept any group address |
| acceptBcast | input | 1 | Accept the all-ones address |
| resultValid | output | 1 | Filter result valid |
| accept | output | 1 | Address accepted |
| isMulticast | output | 1 | Accepted as a group address |
| isBroadcast | output | 1 | Accepted as broadcast |
| loadBusy | output | 1 | Table load in progress |
| loadDone | output | 1 | One-cycle pulse when a load completes |
| resetMode | input | 1 | Enables the host port views |
| entrySel | input | 4 | Entry index for the port views |
| portSel | input | 2 | Which 16-bit view to show |
| portData | output | 16 | Port view data |

## Verification
The bench uses the default parameters: 16 entries, 16-bit address halves and a 5-bit count. A count of 16 fills the whole table, and a count whose upper bits are set shows that only the low five bits are taken. Loads run in both data modes. A zero-count load leaves only the mask fetch. Strobes and a second start command arrive in the middle of a 16-entry load.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int IDX_FIELD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENT_ISSUE,
    ST_ENT_CAP,
    ST_MASK_ISSUE,
    ST_MASK_CAP
  } afState_t;

  typedef struct packed {
    logic                   entryWr;
    logic [IDX_FIELD_W-1:0] entryIdx;
    logic [1:0]             pairSel;
    logic                   maskWr;
    logic [15:0]            wrData;
  } afStrobe_t;
endpackage

// File: rtl/af_datapath.sv
module af_datapath
  import af_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int AW      = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  afStrobe_t        strobe,
  input  logic [AW-1:0]    lookupAddr,
  input  logic             resetMode,
  input  logic [IDX_W-1:0] entrySel,
  input  logic [1:0]       portSel,
  output logic             camHit,
  output logic [15:0]      portData
);
  logic [ENTRIES-1:0][AW-1:0] entryFlat;
  logic [ENTRIES-1:0]         hitVec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [AW-1:0] entryQ;
    logic          maskQ;
    logic          wrHit;

    assign wrHit = strobe.entryWr && (strobe.entryIdx[IDX_W-1:0] == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ <= '0;
      end else if (wrHit) begin
        case (strobe.pairSel)
          2'd0:    entryQ[15:0]  <= strobe.wrData;
          2'd1:    entryQ[31:16] <= strobe.wrData;
          default: entryQ[47:32] <= strobe.wrData;
        endcase
      end
    end

    if (e < 16) begin : g_mask
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskQ <= 1'b0;
        else if (strobe.maskWr) maskQ <= strobe.wrData[e];
      end
    end else begin : g_nomask
      assign maskQ = 1'b0;
    end

    assign entryFlat[e] = entryQ;
    assign hitVec[e]    = maskQ && (entryQ == lookupAddr);
  end

  assign camHit = |hitVec;

  logic [AW-1:0] selEntry;
  assign selEntry = entryFlat[entrySel];

  always_comb begin
    portData = '0;
    if (resetMode) begin
      case (portSel)
        2'd0:    portData = selEntry[47:32];
        2'd1:    portData = selEntry[31:16];
        2'd2:    portData = selEntry[15:0];
        default: portData = '0;
      endcase
    end
  end
endmodule

// File: rtl/af_control.sv
module af_control
  import af_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int CNT_W = 5,
  parameter int AW    = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wide32,
  input  logic               loadStart,
  input  logic [PTR_W-1:0]   segBase,
  input  logic [PTR_W-1:0]   ptrInit,
  input  logic [PTR_W-1:0]   countInit,
  input  logic [31:0]        memRdData,
  output logic               memRdEn,
  output logic [2*PTR_W-1:0] memAddr,
  input  logic               addrValid,
  input  logic [AW-1:0]      lookupAddr,
  input  logic               promisc,
  input  logic               allMulti,
  input  logic               acceptBcast,
  input  logic               camHit,
  output afStrobe_t          strobe,
  output logic               loadBusy,
  output logic               loadDone,
  output logic               resultValid,
  output logic               accept,
  output logic               isMulticast,
  output logic               isBroadcast
);
  localparam int MA_W = 2 * PTR_W;

  afState_t               stateQ;
  logic [PTR_W-1:0]       segQ, ptrQ;
  logic [CNT_W-1:0]       cntQ;
  logic [IDX_FIELD_W-1:0] idxQ;
  logic [1:0]             wordQ;
  logic                   wideQ;

  logic [MA_W-1:0]  wordOff;
  logic [PTR_W-1:0] descStep;
  logic [CNT_W-1:0] startCnt;

  assign startCnt = countInit[CNT_W-1:0];
  assign wordOff  = wideQ ? MA_W'({wordQ, 2'b00}) : MA_W'({wordQ, 1'b0});
  assign descStep = wideQ ? PTR_W'(16) : PTR_W'(8);
  assign memAddr  = {segQ, ptrQ} + wordOff;
  assign memRdEn  = (stateQ == ST_ENT_ISSUE) || (stateQ == ST_MASK_ISSUE);
  assign loadBusy = (stateQ != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.entryWr  = (stateQ == ST_ENT_CAP);
    strobe.entryIdx = idxQ;
    strobe.pairSel  = wordQ - 2'd1;
    strobe.maskWr   = (stateQ == ST_MASK_CAP);
    strobe.wrData   = memRdData[15:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      segQ     <= '0;
      ptrQ     <= '0;
      cntQ     <= '0;
      idxQ     <= '0;
      wordQ    <= '0;
      wideQ    <= 1'b0;
      loadDone <= 1'b0;
    end else begin
      loadDone <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (loadStart) begin
            segQ  <= segBase;
            ptrQ  <= ptrInit;
            wideQ <= wide32;
            cntQ  <= startCnt;
            idxQ  <= '0;
            if (startCnt != '0) begin
              wordQ  <= 2'd1;
              stateQ <= ST_ENT_ISSUE;
            end else begin
              wordQ  <= 2'd0;
              stateQ <= ST_MASK_ISSUE;
            end
          end
        end
        ST_ENT_ISSUE: stateQ <= ST_ENT_CAP;
        ST_ENT_CAP: begin
          if (wordQ == 2'd3) begin
            idxQ <= idxQ + 1'b1;
            cntQ <= cntQ - 1'b1;
            ptrQ <= ptrQ + descStep;
            if (cntQ == CNT_W'(1)) begin
              wordQ  <= 2'd0;
              stateQ <= ST_MASK_ISSUE;
            end else begin
              wordQ  <= 2'd1;
              stateQ <= ST_ENT_ISSUE;
            end
          end else begin
            wordQ  <= wordQ + 2'd1;
            stateQ <= ST_ENT_ISSUE;
          end
        end
        ST_MASK_ISSUE: stateQ <= ST_MASK_CAP;
        ST_MASK_CAP: begin
          loadDone <= 1'b1;
          stateQ   <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  logic decAcc, decMc, decBc, takeAddr;
  assign takeAddr = addrValid && !loadBusy;

  always_comb begin
    decAcc = 1'b0;
    decMc  = 1'b0;
    decBc  = 1'b0;
    if (promisc && !lookupAddr[0]) begin
      decAcc = 1'b1;
    end else if (allMulti && lookupAddr[0]) begin
      decAcc = 1'b1;
      decMc  = 1'b1;
    end else if (acceptBcast && (&lookupAddr)) begin
      decAcc = 1'b1;
      decBc  = 1'b1;
    end else if (camHit) begin
      decAcc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      isMulticast <= 1'b0;
      isBroadcast <= 1'b0;
    end else begin
      resultValid <= takeAddr;
      accept      <= takeAddr && decAcc;
      isMulticast <= takeAddr && decMc;
      isBroadcast <= takeAddr && decBc;
    end
  end
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam
  import af_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PTR_W   = 16,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wide32,
  input  logic                       loadStart,
  input  logic [PTR_W-1:0]           segBase,
  input  logic [PTR_W-1:0]           ptrInit,
  input  logic [PTR_W-1:0]           countInit,
  output logic                       memRdEn,
  output logic [2*PTR_W-1:0]         memAddr,
  input  logic [31:0]                memRdData,
  input  logic                       addrValid,
  input  logic [47:0]                lookupAddr,
  input  logic                       promisc,
  input  logic                       allMulti,
  input  logic                       acceptBcast,
  output logic                       resultValid,
  output logic                       accept,
  output logic                       isMulticast,
  output logic                       isBroadcast,
  output logic                       loadBusy,
  output logic                       loadDone,
  input  logic                       resetMode,
  input  logic [$clog2(ENTRIES)-1:0] entrySel,
  input  logic [1:0]                 portSel,
  output logic [15:0]                portData
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int AW    = 48;

  afStrobe_t strobe;
  logic      camHit;

  af_control #(.PTR_W(PTR_W), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wide32(wide32), .loadStart(loadStart),
    .segBase(segBase), .ptrInit(ptrInit), .countInit(countInit),
    .memRdData(memRdData), .memRdEn(memRdEn), .memAddr(memAddr),
    .addrValid(addrValid), .lookupAddr(lookupAddr), .promisc(promisc),
    .allMulti(allMulti), .acceptBcast(acceptBcast), .camHit(camHit),
    .strobe(strobe), .loadBusy(loadBusy), .loadDone(loadDone),
    .resultValid(resultValid), .accept(accept),
    .isMulticast(isMulticast), .isBroadcast(isBroadcast)
  );

  af_datapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupAddr(lookupAddr),
    .resetMode(resetMode), .entrySel(entrySel), .portSel(portSel),
    .camHit(camHit), .portData(portData)
  );
endmodule

// File: rtl/af_checker.sv
module af_checker (
  input logic        clk,
  input logic        rstN,
  input logic        addrValid,
  input logic        resultValid,
  input logic        accept,
  input logic        isMulticast,
  input logic        isBroadcast,
  input logic        loadBusy,
  input logic        loadDone,
  input logic        memRdEn,
  input logic        resetMode,
  input logic [15:0] portData
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  assert_fetch_in_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> loadBusy);

  assert_result_follows_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(addrValid));

  assert_no_result_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !$past(loadBusy));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(isMulticast && isBroadcast));

  assert_flag_needs_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isMulticast || isBroadcast) |-> (accept && resultValid));

  assert_port_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !resetMode |-> (portData == 16'h0000));
endmodule

bind addr_filter_cam af_checker u_af_checker (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .resultValid(resultValid),
  .accept(accept), .isMulticast(isMulticast), .isBroadcast(isBroadcast),
  .loadBusy(loadBusy), .loadDone(loadDone), .memRdEn(memRdEn),
  .resetMode(resetMode), .portData(portData)
);

// File: tb/addr_filter_cam_bench.sv
`timescale 1ns/1ps
module addr_filter_cam_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        wide32 = 0, loadStart = 0;
  logic [15:0] segBase = 0, ptrInit = 0, countInit = 0;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [31:0] memRdData = 0;
  logic        addrValid = 0;
  logic [47:0] lookupAddr = 0;
  logic        promisc = 0, allMulti = 0, acceptBcast = 0;
  logic        resultValid, accept, isMulticast, isBroadcast, loadBusy, loadDone;
  logic        resetMode = 0;
  logic [3:0]  entrySel = 0;
  logic [1:0]  portSel = 0;
  logic [15:0] portData;

  addr_filter_cam u_addr_filter_cam (
    .clk(clk), .rstN(rstN), .wide32(wide32), .loadStart(loadStart),
    .segBase(segBase), .ptrInit(ptrInit), .countInit(countInit),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .addrValid(addrValid), .lookupAddr(lookupAddr), .promisc(promisc),
    .allMulti(allMulti), .acceptBcast(acceptBcast), .resultValid(resultValid),
    .accept(accept), .isMulticast(isMulticast), .isBroadcast(isBroadcast),
    .loadBusy(loadBusy), .loadDone(loadDone), .resetMode(resetMode),
    .entrySel(entrySel), .portSel(portSel), .portData(portData)
  );

  int checks = 0;
  int fails  = 0;
  bit runChk = 0;

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory: low half from array, upper half junk that must be ignored (R8)
  logic [15:0] memArr [0:511];
  always @(posedge clk)
    if (memRdEn) memRdData <= {memAddr[15:0] ^ 16'hBEEF, memArr[memAddr[9:1]]};

  function automatic logic [31:0] descAddr(logic [15:0] seg, logic [15:0] ptr,
                                           bit wide, int e, int k);
    logic [15:0] p16;
    p16 = ptr + 16'(e * (wide ? 16 : 8));
    return {seg, p16} + 32'(k * (wide ? 4 : 2));
  endfunction

  // behavioural reference model
  logic [7:0]  camB [16][6];
  logic [15:0] maskM = 0;
  int          rem = 0;
  int          ldN = 0;
  logic [15:0] ldSeg = 0, ldPtr = 0;
  bit          ldWide = 0;
  logic [31:0] addrQ [$];
  bit          busyM, expValid, expAcc, expMc, expBc, expDone;
  int          expRule;

  function automatic bit camMatch(logic [47:0] a);
    for (int e = 0; e < 16; e++) begin
      bit same = 1;
      for (int b = 0; b < 6; b++) if (camB[e][b] != a[8*b +: 8]) same = 0;
      if (maskM[e] && same) return 1;
    end
    return 0;
  endfunction

  function automatic int ruleOf(logic [47:0] a, bit p, bit m, bit b);
    if (p && !a[0]) return 1;
    if (m && a[0]) return 2;
    if (b && (a == 48'hFFFF_FFFF_FFFF)) return 3;
    if (camMatch(a)) return 4;
    return 5;
  endfunction

  function automatic string ruleTag(int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic applyLoad();
    for (int e = 0; e < ldN; e++)
      for (int k = 1; k <= 3; k++) begin
        logic [31:0] a;
        logic [15:0] w;
        a = descAddr(ldSeg, ldPtr, ldWide, e, k);
        w = memArr[a[9:1]];
        camB[e % 16][2*(k-1)]   = w[7:0];
        camB[e % 16][2*(k-1)+1] = w[15:8];
      end
    begin
      logic [31:0] a;
      a = descAddr(ldSeg, ldPtr, ldWide, ldN, 0);
      maskM = memArr[a[9:1]];
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      rem = 0; expValid = 0; expAcc = 0; expMc = 0; expBc = 0; expDone = 0;
      maskM = 0;
      for (int e = 0; e < 16; e++) for (int b = 0; b < 6; b++) camB[e][b] = 0;
      addrQ.delete();
    end else begin
      busyM    = (rem > 0);
      expDone  = 0;
      expValid = addrValid && !busyM;
      expRule  = ruleOf(lookupAddr, promisc, allMulti, acceptBcast);
      expAcc   = expValid && (expRule != 5);
      expMc    = expValid && (expRule == 2);
      expBc    = expValid && (expRule == 3);
      if (busyM) begin
        rem--;
        if (rem == 0) begin
          applyLoad();
          expDone = 1;
        end
      end else if (loadStart) begin
        ldN = int'(countInit[4:0]); ldSeg = segBase; ldPtr = ptrInit; ldWide = wide32;
        rem = 6 * ldN + 2;
        for (int e = 0; e < ldN; e++)
          for (int k = 1; k <= 3; k++) addrQ.push_back(descAddr(ldSeg, ldPtr, ldWide, e, k));
        addrQ.push_back(descAddr(ldSeg, ldPtr, ldWide, ldN, 0));
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (runChk) begin
      chk("R6 resultValid", 48'(resultValid), 48'(expValid));
      if (expValid) begin
        chk({ruleTag(expRule), " accept"}, 48'(accept), 48'(expAcc));
        chk({ruleTag(expRule), " multicast"}, 48'(isMulticast), 48'(expMc));
        chk({ruleTag(expRule), " broadcast"}, 48'(isBroadcast), 48'(expBc));
      end
      chk("R9 loadBusy", 48'(loadBusy), 48'(rem > 0));
      chk("R9 loadDone", 48'(loadDone), 48'(expDone));
      if (memRdEn) begin
        if (addrQ.size() == 0) chk("R7 unexpected read", 48'(memAddr), 48'hFFFF_FFFF);
        else chk("R7 read address", 48'(memAddr), 48'(addrQ.pop_front()));
      end
    end
  end

  task automatic present(logic [47:0] a, bit p, bit m, bit b,
                         bit eAcc, bit eMc, bit eBc, string tag);
    @(negedge clk);
    addrValid = 1; lookupAddr = a; promisc = p; allMulti = m; acceptBcast = b;
    @(negedge clk);
    addrValid = 0;
    chk({tag, " direct valid"}, 48'(resultValid), 48'h1);
    chk({tag, " direct accept"}, 48'(accept), 48'(eAcc));
    chk({tag, " direct mc"}, 48'(isMulticast), 48'(eMc));
    chk({tag, " direct bc"}, 48'(isBroadcast), 48'(eBc));
  endtask

  task automatic startLoad(logic [15:0] seg, logic [15:0] ptr, logic [15:0] cnt, bit wide);
    @(negedge clk);
    segBase = seg; ptrInit = ptr; countInit = cnt; wide32 = wide; loadStart = 1;
    @(negedge clk);
    loadStart = 0;
  endtask

  task automatic waitDone();
    while (loadBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic portChk(bit rm, logic [3:0] idx, logic [1:0] sel,
                         logic [15:0] exp, string tag);
    @(negedge clk);
    resetMode = rm; entrySel = idx; portSel = sel;
    #1;
    chk(tag, 48'(portData), 48'(exp));
  endtask

  task automatic putEntry(logic [15:0] ptr, bit wide, int e, logic [47:0] v);
    for (int k = 1; k <= 3; k++) begin
      logic [31:0] a;
      a = descAddr(16'h0, ptr, wide, e, k);
      memArr[a[9:1]] = v[16*(k-1) +: 16];
    end
  endtask

  task automatic putMask(logic [15:0] ptr, bit wide, int n, logic [15:0] m);
    logic [31:0] a;
    a = descAddr(16'h0, ptr, wide, n, 0);
    memArr[a[9:1]] = m;
  endtask

  localparam logic [47:0] A0 = 48'h6655_4433_2210;
  localparam logic [47:0] A1 = 48'hCAFE_BABE_0040;
  localparam logic [47:0] A2 = 48'h1234_5678_9AB0;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  function automatic logic [47:0] bigEntry(int e);
    return {8'(e), 40'h55_6677_8800};
  endfunction

  initial begin
    for (int i = 0; i < 512; i++) memArr[i] = 16'(i * 16'h03B1) ^ 16'h5A5A;

    repeat (3) @(negedge clk);
    // reset state
    chk("R6 reset resultValid", 48'(resultValid), 48'h0);
    chk("R9 reset loadBusy", 48'(loadBusy), 48'h0);
    chk("R9 reset loadDone", 48'(loadDone), 48'h0);
    chk("R7 reset memRdEn", 48'(memRdEn), 48'h0);
    rstN = 1;
    runChk = 1;

    // load 1: 16-bit mode, 3 entries, entry 1 disabled
    putEntry(16'h0040, 0, 0, A0);
    putEntry(16'h0040, 0, 1, A1);
    putEntry(16'h0040, 0, 2, A2);
    putMask(16'h0040, 0, 3, 16'h0005);
    startLoad(16'h0012, 16'h0040, 16'h0003, 0);
    waitDone();

    present(A0, 0, 0, 0, 1, 0, 0, "R4 enabled entry");
    present(A2, 0, 0, 0, 1, 0, 0, "R4 entry2");
    present(A1, 0, 0, 0, 0, 0, 0, "R4 disabled entry");
    present(48'h0102_0304_0506, 0, 0, 0, 0, 0, 0, "R5 unknown");
    present(48'h0102_0304_0506, 1, 0, 0, 1, 0, 0, "R1 promisc unicast");
    present(48'h0102_0304_0507, 1, 0, 0, 0, 0, 0, "R5 promisc group");
    present(48'h0102_0304_0507, 0, 1, 0, 1, 1, 0, "R2 all multicast");
    present(BC, 0, 1, 1, 1, 1, 0, "R2 priority over bcast");
    present(BC, 0, 0, 1, 1, 0, 1, "R3 broadcast");
    present(BC, 0, 0, 0, 0, 0, 0, "R5 broadcast off");

    // host port views (R8 byte order shows here too)
    portChk(1, 4'd0, 2'd2, A0[15:0], "R8 entry0 bytes1:0");
    portChk(1, 4'd0, 2'd1, A0[31:16], "R10 entry0 bytes3:2");
    portChk(1, 4'd0, 2'd0, A0[47:32], "R10 entry0 bytes5:4");
    portChk(1, 4'd2, 2'd0, A2[47:32], "R10 entry2 bytes5:4");
    portChk(1, 4'd2, 2'd3, 16'h0000, "R10 sel3 zero");
    portChk(0, 4'd0, 2'd2, 16'h0000, "R10 gated");

    // load 2: 32-bit mode, count 16 from 0x30, busy strobe and ignored restart
    for (int e = 0; e < 16; e++) putEntry(16'h0100, 1, e, bigEntry(e));
    putMask(16'h0100, 1, 16, 16'hFFFF);
    startLoad(16'h0003, 16'h0100, 16'h0030, 1);
    @(negedge clk);
    addrValid = 1; lookupAddr = A0; promisc = 1; allMulti = 0; acceptBcast = 0;
    @(negedge clk);
    addrValid = 0;
    chk("R6 no result while busy", 48'(resultValid), 48'h0);
    segBase = 16'h0777; ptrInit = 16'h0200; countInit = 16'h0002; loadStart = 1;
    @(negedge clk);
    loadStart = 0;
    waitDone();

    present(bigEntry(15), 0, 0, 0, 1, 0, 0, "R4 entry15 wide");
    present(bigEntry(7), 0, 0, 0, 1, 0, 0, "R8 entry7 wide");
    present(A0, 0, 0, 0, 0, 0, 0, "R5 overwritten");
    portChk(1, 4'd15, 2'd0, bigEntry(15)[47:32], "R8 wide entry15 bytes5:4");
    portChk(1, 4'd9, 2'd2, bigEntry(9)[15:0], "R8 wide entry9 bytes1:0");
    portChk(0, 4'd9, 2'd2, 16'h0000, "R10 gated again");

    // load 3: zero count, mask only
    putMask(16'h0300, 0, 0, 16'h0000);
    startLoad(16'h0000, 16'h0300, 16'h0020, 0);
    waitDone();
    present(bigEntry(15), 0, 0, 0, 0, 0, 0, "R9 mask cleared");
    portChk(1, 4'd15, 2'd0, bigEntry(15)[47:32], "R7 entries kept");

    repeat (3) @(negedge clk);
    chk("R7 all reads seen", 48'(addrQ.size()), 48'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule